// File: doc/BRIEF.md
# UART Queue Watermark Interrupt Unit

This block sits next to a UART's serial shifter. It holds one byte queue for outgoing data and one for incoming data, and it raises a single interrupt request toward the platform interrupt controller. The request is not driven by plain empty or non-empty events. Each direction compares its queue fill level against a software-set threshold. The receive side flags when the fill level rises above its threshold. The transmit side flags when the fill level falls below its threshold.

Software uses a small register port to queue bytes for sending, take received bytes, and set the thresholds and enables. It can also read the pending flags, which show the raw comparison results whatever the enable bits say. The shifter is modelled at byte level. `tx_drain` takes the head byte of the transmit queue, and `rx_fill` with `rx_byte` delivers one received byte.

Top module: `uart_wm_irq`

## Requirements
- R1: After reset both queues are empty, both thresholds read 0, both enables read 0, the pending register reads 0 and `irq` is low.
- R2: The transmit queue holds DEPTH (8) bytes and presents them on `tx_byte` in push order. `tx_avail` is high while it holds data, and `tx_drain` removes the head. A push to a full transmit queue is dropped.
- R3: The receive queue holds DEPTH (8) bytes and returns them in arrival order. A fill strobe while it is full is dropped.
- R4: A read of address 1 while the receive queue is empty raises `bus_rd_invalid` in that cycle, returns 0 and leaves the fill level at 0.
- R5: Receive pending (pending register bit 1) is high exactly when the receive fill level is strictly greater than the receive threshold. With a threshold of 0 it is high whenever at least one byte waits.
- R6: Transmit pending (pending register bit 0) is high exactly when the transmit fill level is strictly less than the transmit threshold. A threshold of 0 never flags, and a threshold of 1 flags only when the queue is empty.
- R7: Both pending bits follow the fill levels whatever the enable bits hold, and they drop as soon as the comparison stops holding. No clear is needed.
- R8: `irq` = (transmit pending AND enable bit 0) OR (receive pending AND enable bit 1).
- R9: Register map (3-bit address, data 8 bits):
  - 0: write pushes a transmit byte; read returns the transmit fill level.
  - 1: read pops a receive byte.
  - 2: transmit threshold in bits [2:0].
  - 3: receive threshold in bits [2:0].
  - 4: enables, bit 0 for transmit and bit 1 for receive.
  - 5: pending, read-only; writes are ignored.
  - 6: read returns the receive fill level.
  - Reads are combinational in the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_rd_invalid | output | 1 | Pop attempted on an empty receive queue |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_avail | output | 1 | Transmit queue holds data |
| tx_drain | input | 1 | Shifter takes the head byte |
| rx_byte | input | 8 | Byte from the shifter |
| rx_fill | input | 1 | Store `rx_byte` in the receive queue |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default DEPTH of 8, which gives 3-bit thresholds. Nine pushes are enough to reach the full and overflow boundaries of either queue. Both threshold extremes, 0 and 7, can be written directly. This makes it possible to test the strict comparisons at fill levels 6, 7 and 8 against a threshold of 7, and to test the edge at which a threshold of 1 flags an empty transmit queue.

// File: rtl/uart_wm_pkg.sv
// Package: register addresses shared by the watermark interrupt unit and its bench.
package uart_wm_pkg;
    typedef enum logic [2:0] {
        REG_TXQ   = 3'd0,
        REG_RXQ   = 3'd1,
        REG_TXWM  = 3'd2,
        REG_RXWM  = 3'd3,
        REG_IE    = 3'd4,
        REG_IP    = 3'd5,
        REG_RXCNT = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/byte_fifo.sv
// byte_fifo: synchronous first-in first-out queue with a fill-level output.
// A push while full is dropped, and so is a pop while empty. Push and pop may
// occur in the same cycle. DEPTH is assumed to be a power of two.
module byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    // Qualify requests against the current fill level.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Storage write; no reset needed, since the pointers guard every read.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Guards shared by R2 (transmit) and R3 (receive).
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/wm_pending.sv
// wm_pending: compares a fill level with a threshold. With ABOVE=1 it flags
// fill > threshold (receive style); with ABOVE=0 it flags fill < threshold
// (transmit style). The result is purely combinational.
module wm_pending #(
    parameter int  WM_W  = 3,
    parameter bit  ABOVE = 1'b1,
    localparam int CW    = WM_W + 1
) (
    input  logic [CW-1:0]   level,
    input  logic [WM_W-1:0] mark,
    output logic            pend
);
    logic [CW-1:0] mark_x;
    // Widen the threshold to the width of the fill level.
    always_comb mark_x = {1'b0, mark};

    generate
        if (ABOVE) begin : g_above
            // Receive rule: strictly above the threshold.
            always_comb pend = (level > mark_x);
        end else begin : g_below
            // Transmit rule: strictly below the threshold.
            always_comb pend = (level < mark_x);
        end
    endgenerate
endmodule

// File: rtl/uart_wm_irq.sv
// uart_wm_irq: holds transmit and receive byte queues with threshold-based
// pending flags and one combined interrupt request. It assumes a single-cycle
// register strobe and byte-level shifter strobes, and that DEPTH is a power of two.
module uart_wm_irq
    import uart_wm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int WM_W = $clog2(DEPTH),
    localparam int CW   = WM_W + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_rd_invalid,
    output logic [7:0] tx_byte,
    output logic       tx_avail,
    input  logic       tx_drain,
    input  logic [7:0] rx_byte,
    input  logic       rx_fill,
    output logic       irq
);
    reg_addr_e       addr;
    logic            wr_en, rd_en;
    logic [WM_W-1:0] tx_wm, rx_wm;
    logic            tx_ie, rx_ie;
    logic            tx_push, rx_pop;
    logic [CW-1:0]   tx_count, rx_count;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]      rx_head;
    logic            tx_pend, rx_pend;

    // Decode the register strobe.
    always_comb begin
        addr    = reg_addr_e'(bus_addr);
        wr_en   = bus_valid && bus_write;
        rd_en   = bus_valid && !bus_write;
        tx_push = wr_en && (addr == REG_TXQ);
        rx_pop  = rd_en && (addr == REG_RXQ);
    end

    // Software-writable thresholds and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_wm <= '0;
            rx_wm <= '0;
            tx_ie <= 1'b0;
            rx_ie <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                REG_TXWM: tx_wm <= bus_wdata[WM_W-1:0];
                REG_RXWM: rx_wm <= bus_wdata[WM_W-1:0];
                REG_IE: begin
                    tx_ie <= bus_wdata[0];
                    rx_ie <= bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(bus_wdata),
        .pop(tx_drain), .dout(tx_byte),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_fill), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    wm_pending #(.WM_W(WM_W), .ABOVE(1'b0)) u_tx_pend (
        .level(tx_count), .mark(tx_wm), .pend(tx_pend)
    );

    wm_pending #(.WM_W(WM_W), .ABOVE(1'b1)) u_rx_pend (
        .level(rx_count), .mark(rx_wm), .pend(rx_pend)
    );

    // Shifter-side status and the combined request.
    always_comb begin
        tx_avail = !tx_empty;
        irq      = (tx_pend && tx_ie) || (rx_pend && rx_ie);
    end

    // Combinational read mux and the empty-pop flag.
    always_comb begin
        bus_rdata      = '0;
        bus_rd_invalid = rx_pop && rx_empty;
        case (addr)
            REG_TXQ:   bus_rdata = 8'(tx_count);
            REG_RXQ:   bus_rdata = rx_empty ? 8'h00 : rx_head;
            REG_TXWM:  bus_rdata = 8'(tx_wm);
            REG_RXWM:  bus_rdata = 8'(rx_wm);
            REG_IE:    bus_rdata = {6'b0, rx_ie, tx_ie};
            REG_IP:    bus_rdata = {6'b0, rx_pend, tx_pend};
            REG_RXCNT: bus_rdata = 8'(rx_count);
            default:   bus_rdata = '0;
        endcase
    end

    assert_tx_wm_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wm == '0) |-> !tx_pend);
    assert_tx_full_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_pend);
    assert_rx_any_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_wm == '0) && !rx_empty) |-> rx_pend);
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie && !rx_ie) |-> !irq);
    assert_ip_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_IP) |=> ($stable(tx_wm) && $stable(rx_wm) && $stable(tx_ie) && $stable(rx_ie)));
    assert_rx_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_fill && !rx_pop) |=> (rx_count == CW'(DEPTH)));
endmodule

// File: tb/uart_wm_irq_bench.sv
`timescale 1ns/1ps
module uart_wm_irq_bench;
    import uart_wm_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rd_invalid;
    logic [7:0] tx_byte;
    logic       tx_avail;
    logic       tx_drain = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_fill = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] mon_exp;

    always #2.5 clk = ~clk;

    uart_wm_irq u_uart_wm_irq (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_invalid(bus_rd_invalid),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_drain(tx_drain),
        .rx_byte(rx_byte), .rx_fill(rx_fill), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d, output logic inv);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1; d = bus_rdata; inv = bus_rd_invalid;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    // Driver: push a transmit byte and record the expectation.
    task automatic tx_push(input logic [7:0] b);
        if (tx_q.size() < 8) tx_q.push_back(b);
        bus_wr(REG_TXQ, b);
    endtask

    task automatic tx_take();
        @(negedge clk); tx_drain = 1'b1;
        @(posedge clk); #1; tx_drain = 1'b0;
    endtask

    // Driver: deliver a received byte and record the expectation.
    task automatic rx_put(input logic [7:0] b);
        if (rx_q.size() < 8) rx_q.push_back(b);
        @(negedge clk); rx_fill = 1'b1; rx_byte = b;
        @(posedge clk); #1; rx_fill = 1'b0;
    endtask

    // Read one received byte and compare it with the scoreboard.
    task automatic rx_take();
        logic [7:0] d; logic inv; logic [7:0] e;
        bus_rd(REG_RXQ, d, inv);
        if (rx_q.size() == 0) begin
            check(inv == 1'b1, "R4 invalid flag", int'(inv), 1);
            check(d == 8'h00, "R4 data", int'(d), 0);
        end else begin
            e = rx_q.pop_front();
            check(inv == 1'b0 && d == e, "R3 rx order", int'(d), int'(e));
        end
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] d; logic inv;
        bus_rd(a, d, inv);
        check(d == e, req, int'(d), int'(e));
    endtask

    task automatic expect_irq(input logic e, input string req);
        @(negedge clk); #1;
        check(irq == e, req, int'(irq), int'(e));
    endtask

    // Monitor: compare every drained transmit byte against the scoreboard.
    always @(negedge clk) begin
        #2;
        if (tx_drain && tx_avail) begin
            if (tx_q.size() == 0) begin
                check(1'b0, "R2 unexpected tx byte", int'(tx_byte), -1);
            end else begin
                mon_exp = tx_q.pop_front();
                check(tx_byte == mon_exp, "R2 tx order", int'(tx_byte), int'(mon_exp));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_irq(1'b0, "R1 irq");
        check(tx_avail == 1'b0, "R1 tx_avail", int'(tx_avail), 0);
        expect_reg(REG_IP, 8'h00, "R1 pending");
        expect_reg(REG_TXWM, 8'h00, "R1 tx threshold");
        expect_reg(REG_RXWM, 8'h00, "R1 rx threshold");
        expect_reg(REG_IE, 8'h00, "R1 enables");
        expect_reg(REG_RXCNT, 8'h00, "R1 rx level");

        // R6 threshold 1 flags an empty queue; R7 visible with enables off
        bus_wr(REG_TXWM, 8'h01);
        expect_reg(REG_IP, 8'h01, "R6 wm1 empty");
        expect_irq(1'b0, "R7 pending without enable");
        bus_wr(REG_IE, 8'h01);
        expect_irq(1'b1, "R8 tx irq");
        tx_push(8'hA5);
        expect_reg(REG_IP, 8'h00, "R6 wm1 one byte");
        expect_irq(1'b0, "R7 drops without clear");
        tx_take();

        // R2 fill beyond capacity; the ninth push is dropped
        for (int i = 0; i < 9; i++) tx_push(8'(8'h10 + i));
        expect_reg(REG_TXQ, 8'd8, "R2 full level");
        check(tx_avail == 1'b1, "R2 tx_avail", int'(tx_avail), 1);
        for (int i = 0; i < 8; i++) tx_take();
        expect_reg(REG_TXQ, 8'd0, "R2 drained");
        tx_take();
        check(tx_avail == 1'b0, "R2 empty after extra drain", int'(tx_avail), 0);

        // R6 boundary at threshold 7
        bus_wr(REG_TXWM, 8'h07);
        for (int i = 0; i < 6; i++) tx_push(8'(8'h40 + i));
        expect_reg(REG_IP, 8'h01, "R6 six below seven");
        tx_push(8'h46);
        expect_reg(REG_IP, 8'h00, "R6 seven not below seven");
        tx_push(8'h47);
        expect_reg(REG_IP, 8'h00, "R6 full");
        for (int i = 0; i < 8; i++) tx_take();
        bus_wr(REG_TXWM, 8'h00);
        expect_reg(REG_IP, 8'h00, "R6 wm0 never");
        bus_wr(REG_IE, 8'h00);

        // R5 receive rule
        rx_put(8'hC1);
        expect_reg(REG_IP, 8'h02, "R5 wm0 one byte");
        expect_irq(1'b0, "R7 rx pending without enable");
        bus_wr(REG_RXWM, 8'h03);
        expect_reg(REG_IP, 8'h00, "R5 one not above three");
        rx_put(8'hC2); rx_put(8'hC3);
        expect_reg(REG_IP, 8'h00, "R5 three not above three");
        rx_put(8'hC4);
        expect_reg(REG_IP, 8'h02, "R5 four above three");
        bus_wr(REG_IE, 8'h02);
        expect_irq(1'b1, "R8 rx irq");

        // R9 write to the pending register is ignored
        bus_wr(REG_IP, 8'h00);
        expect_reg(REG_IP, 8'h02, "R9 pending read-only");
        expect_reg(REG_IE, 8'h02, "R9 enables kept");

        // R3 overflow of the receive queue
        for (int i = 0; i < 5; i++) rx_put(8'(8'hD0 + i));
        expect_reg(REG_RXCNT, 8'd8, "R3 full level");
        for (int i = 0; i < 8; i++) rx_take();
        expect_irq(1'b0, "R8 rx irq drops when drained");

        // R4 pop while empty
        rx_take();
        expect_reg(REG_RXCNT, 8'd0, "R4 level stays zero");

        // R8 both sources enabled
        bus_wr(REG_TXWM, 8'h01);
        bus_wr(REG_IE, 8'h03);
        expect_irq(1'b1, "R8 combined");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule